// File: doc/BRIEF.md
# Data Memory Address Generator

This block produces the 8-bit data memory address for a small fixed-point signal processing core. On each cycle it decodes the low byte of the current instruction word. The access is either direct or indirect, and an instruction with an immediate operand or no instruction at all makes no access. A direct access joins a 1-bit page register, as the most significant bit, with a 7-bit offset taken from the instruction. Page 0 spans 128 words and page 1 spans up to 128 words. An indirect access uses the low byte of one of two 16-bit auxiliary registers, picked by a 1-bit selector register.

An indirect access can also step the selected register up or down by one, and it can give the selector a new value. These updates take effect at the next clock edge, together with the access. The address itself is formed in the same cycle from the values held before any update. Separate load strobes write the page register, either auxiliary register and the selector. In the decoder, each instruction falls into one of three access kinds, ACC_IDLE, ACC_DIRECT or ACC_INDIRECT, and the update field falls into one of three step kinds, UPD_NONE, UPD_DEC or UPD_INC. Every instruction is classified afresh on each cycle, so the decoder has no transitions between kinds.

Top module: `data_addr_gen`

## Requirements
- R1: When insn_en is 1, insn_imm is 0 and instruction bit 7 is 0, the access is direct. In the same cycle dmem_addr equals {page register, instruction bits 6:0} and dmem_addr_vld is 1.
- R2: When insn_en is 1, insn_imm is 0 and instruction bit 7 is 1, the access is indirect. In the same cycle dmem_addr equals the low 8 bits of the auxiliary register picked by the selector (0 picks the first register, 1 picks the second), using its value from before any update in that cycle. dmem_addr_vld is 1.
- R3: On an indirect access, instruction bits 5:4 choose the step applied to the picked register at the next edge: 01 decrements it, 10 increments it, and 00 or 11 leave it unchanged. The arithmetic wraps modulo 2^16, so 0x0000 decremented becomes 0xFFFF and 0xFFFF incremented becomes 0x0000.
- R4: On an indirect access with instruction bit 3 set, the selector takes the value of instruction bit 0 at the next edge. A step in the same instruction applies to the register that was picked before the selector changed.
- R5: When insn_en is 0 or insn_imm is 1, dmem_addr_vld is 0, and neither the selector nor any auxiliary register changes because of the instruction bits.
- R6: page_ld, aux_ld (with aux_sel choosing the register) and ptr_ld write page_val, aux_val and ptr_val at the next edge. A load has priority over an update from the instruction to the same register in the same cycle.
- R7: A synchronous reset clears the page register, both auxiliary registers and the selector to 0. dmem_addr_vld is 0 during any cycle in which rst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_en | input | 1 | An instruction is presented this cycle |
| insn_imm | input | 1 | The presented instruction has an immediate operand |
| insn_word | input | 16 | Instruction word; bits 7:0 are decoded |
| page_ld | input | 1 | Load strobe for the page register |
| page_val | input | 1 | New page register value |
| aux_ld | input | 1 | Load strobe for an auxiliary register |
| aux_sel | input | 1 | Which auxiliary register aux_ld writes |
| aux_val | input | 16 | New auxiliary register value |
| ptr_ld | input | 1 | Load strobe for the selector |
| ptr_val | input | 1 | New selector value |
| dmem_addr | output | 8 | Data memory address |
| dmem_addr_vld | output | 1 | dmem_addr is a valid access address |

## Verification
The address and its valid flag are combinational outputs, so they are due in the same cycle as the instruction. The bench drives each input set on a falling edge and samples one nanosecond later, before the next rising edge. Register changes from loads, steps, selector updates and reset are due one edge later. They are observed through the address of a later indirect or direct access. The vector table therefore pairs each state-changing cycle with a following access that exposes its result, including same-cycle conflicts between loads and updates.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int AUX_N = 2;
    localparam int PTR_W = 1;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_DIRECT,
        ACC_INDIRECT
    } acc_kind_e;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_DEC,
        UPD_INC
    } upd_e;

    typedef struct packed {
        acc_kind_e        kind;
        upd_e             upd;
        logic             ptr_chg;
        logic [PTR_W-1:0] ptr_new;
    } dec_t;

endpackage

// File: rtl/dag_decode.sv
module dag_decode
    import dag_pkg::*;
#(
    parameter int INSN_W = 16
) (
    input  logic              en,
    input  logic              imm,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    localparam int MODE_BIT = 7;
    localparam int UPD_HI   = 5;
    localparam int UPD_LO   = 4;
    localparam int PCHG_BIT = 3;

    always_comb begin
        dec.kind    = ACC_IDLE;
        dec.upd     = UPD_NONE;
        dec.ptr_chg = 1'b0;
        dec.ptr_new = insn[PTR_W-1:0];
        if (en && !imm) begin
            if (insn[MODE_BIT]) begin
                dec.kind    = ACC_INDIRECT;
                dec.ptr_chg = insn[PCHG_BIT];
                unique case (insn[UPD_HI:UPD_LO])
                    2'b01:   dec.upd = UPD_DEC;
                    2'b10:   dec.upd = UPD_INC;
                    default: dec.upd = UPD_NONE;
                endcase
            end else begin
                dec.kind = ACC_DIRECT;
            end
        end
    end
endmodule

// File: rtl/dag_aux_bank.sv
module dag_aux_bank
    import dag_pkg::*;
#(
    parameter int AR_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PTR_W-1:0]           sel,
    input  upd_e                       upd,
    input  logic                       ld,
    input  logic [PTR_W-1:0]           ld_sel,
    input  logic [AR_W-1:0]            ld_val,
    output logic [AUX_N-1:0][AR_W-1:0] q
);
    for (genvar g = 0; g < AUX_N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (ld && ld_sel == PTR_W'(g)) begin
                q[g] <= ld_val;
            end else if (sel == PTR_W'(g)) begin
                unique case (upd)
                    UPD_INC: q[g] <= q[g] + AR_W'(1);
                    UPD_DEC: q[g] <= q[g] - AR_W'(1);
                    default: q[g] <= q[g];
                endcase
            end
        end
    end
endmodule

// File: rtl/dag_ptr_regs.sv
module dag_ptr_regs
    import dag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             page_ld,
    input  logic             page_val,
    input  logic             ptr_ld,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             ptr_chg,
    input  logic [PTR_W-1:0] ptr_new,
    output logic             page_q,
    output logic [PTR_W-1:0] ptr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if (page_ld) page_q <= page_val;
            if (ptr_ld)       ptr_q <= ptr_val;
            else if (ptr_chg) ptr_q <= ptr_new;
        end
    end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
    import dag_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int OFS_W  = 7,
    parameter int AR_W   = 16,
    localparam int ADDR_W = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_en,
    input  logic              insn_imm,
    input  logic [INSN_W-1:0] insn_word,
    input  logic              page_ld,
    input  logic              page_val,
    input  logic              aux_ld,
    input  logic              aux_sel,
    input  logic [AR_W-1:0]   aux_val,
    input  logic              ptr_ld,
    input  logic              ptr_val,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic              dmem_addr_vld
);
    dec_t                       dec;
    logic                       page_q;
    logic [PTR_W-1:0]           ptr_q;
    logic [AUX_N-1:0][AR_W-1:0] aux_q;

    dag_decode #(.INSN_W(INSN_W)) u_dec (
        .en   (insn_en),
        .imm  (insn_imm),
        .insn (insn_word),
        .dec  (dec)
    );

    dag_ptr_regs u_ptr (
        .clk      (clk),
        .rst      (rst),
        .page_ld  (page_ld),
        .page_val (page_val),
        .ptr_ld   (ptr_ld),
        .ptr_val  (ptr_val),
        .ptr_chg  (dec.ptr_chg),
        .ptr_new  (dec.ptr_new),
        .page_q   (page_q),
        .ptr_q    (ptr_q)
    );

    dag_aux_bank #(.AR_W(AR_W)) u_aux (
        .clk    (clk),
        .rst    (rst),
        .sel    (ptr_q),
        .upd    (dec.upd),
        .ld     (aux_ld),
        .ld_sel (aux_sel),
        .ld_val (aux_val),
        .q      (aux_q)
    );

    always_comb begin
        unique case (dec.kind)
            ACC_DIRECT:   dmem_addr = {page_q, insn_word[OFS_W-1:0]};
            ACC_INDIRECT: dmem_addr = aux_q[ptr_q][ADDR_W-1:0];
            default:      dmem_addr = '0;
        endcase
        dmem_addr_vld = !rst && (dec.kind != ACC_IDLE);
    end
endmodule

// File: rtl/dag_checker.sv
module dag_checker
    import dag_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int AR_W   = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       insn_en,
    input logic                       insn_imm,
    input logic [INSN_W-1:0]          insn_word,
    input logic                       aux_ld,
    input logic                       aux_sel,
    input logic                       ptr_ld,
    input logic                       ptr_val,
    input logic [7:0]                 dmem_addr,
    input logic                       dmem_addr_vld,
    input logic                       page_q,
    input logic [PTR_W-1:0]           ptr_q,
    input logic [AUX_N-1:0][AR_W-1:0] aux_q
);
    logic acc_ind, acc_dir, aux_hit;
    assign acc_ind = insn_en && !insn_imm && insn_word[7];
    assign acc_dir = insn_en && !insn_imm && !insn_word[7];
    assign aux_hit = aux_ld && (aux_sel == ptr_q);

    assert_direct_addr_R1: assert property (@(posedge clk) disable iff (rst)
        acc_dir |-> (dmem_addr_vld && dmem_addr == {page_q, insn_word[6:0]}));

    assert_indirect_addr_R2: assert property (@(posedge clk) disable iff (rst)
        acc_ind |-> (dmem_addr_vld && dmem_addr == aux_q[ptr_q][7:0]));

    assert_step_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_ind && insn_word[5:4] == 2'b10 && !aux_hit) |=>
        (($past(ptr_q) ? aux_q[1] : aux_q[0]) ==
         AR_W'($past(ptr_q ? aux_q[1] : aux_q[0]) + AR_W'(1))));

    assert_step_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_ind && insn_word[5:4] == 2'b01 && !aux_hit) |=>
        (($past(ptr_q) ? aux_q[1] : aux_q[0]) ==
         AR_W'($past(ptr_q ? aux_q[1] : aux_q[0]) - AR_W'(1))));

    assert_ptr_change_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_ind && insn_word[3] && !ptr_ld) |=> (ptr_q == $past(insn_word[0])));

    assert_no_access_R5: assert property (@(posedge clk) disable iff (rst)
        (!insn_en || insn_imm) |-> !dmem_addr_vld);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ((!insn_en || insn_imm) && !aux_ld && !ptr_ld) |=> ($stable(aux_q) && $stable(ptr_q)));

    assert_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
        ptr_ld |=> (ptr_q == $past(ptr_val)));

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!page_q && ptr_q == '0 && aux_q == '0));

    always_comb begin
        if (rst) assert_reset_vld_R7: assert (!dmem_addr_vld);
    end
endmodule

bind data_addr_gen dag_checker #(.INSN_W(INSN_W), .AR_W(AR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .insn_en       (insn_en),
    .insn_imm      (insn_imm),
    .insn_word     (insn_word),
    .aux_ld        (aux_ld),
    .aux_sel       (aux_sel),
    .ptr_ld        (ptr_ld),
    .ptr_val       (ptr_val),
    .dmem_addr     (dmem_addr),
    .dmem_addr_vld (dmem_addr_vld),
    .page_q        (page_q),
    .ptr_q         (ptr_q),
    .aux_q         (aux_q)
);

// File: tb/data_addr_gen_bench.sv
module data_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_en = 1'b0, insn_imm = 1'b0;
    logic [15:0] insn_word = '0;
    logic        page_ld = 1'b0, page_val = 1'b0;
    logic        aux_ld = 1'b0, aux_sel = 1'b0;
    logic [15:0] aux_val = '0;
    logic        ptr_ld = 1'b0, ptr_val = 1'b0;
    logic [7:0]  dmem_addr;
    logic        dmem_addr_vld;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    data_addr_gen u_data_addr_gen (
        .clk(clk), .rst(rst), .insn_en(insn_en), .insn_imm(insn_imm),
        .insn_word(insn_word), .page_ld(page_ld), .page_val(page_val),
        .aux_ld(aux_ld), .aux_sel(aux_sel), .aux_val(aux_val),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .dmem_addr(dmem_addr), .dmem_addr_vld(dmem_addr_vld)
    );

    typedef struct packed {
        logic        en, imm;
        logic [7:0]  insn;
        logic        pl, pv, al, as;
        logic [15:0] av;
        logic        xl, xv, evld;
        logic [7:0]  eaddr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd7}, // R7 AR0 cleared
        '{1'b1,1'b0,8'h05, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h05, 4'd1}, // R1 page 0
        '{1'b1,1'b0,8'h10, 1'b1,1'b1,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h10, 4'd6}, // R6 old page used
        '{1'b1,1'b0,8'h7F, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'hFF, 4'd1}, // R1 page 1
        '{1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,16'h1234, 1'b0,1'b0, 1'b0,8'h00, 4'd6}, // R6 load AR0
        '{1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b1,16'h00FF, 1'b0,1'b0, 1'b0,8'h00, 4'd6}, // R6 load AR1
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h34, 4'd2}, // R2 AR0
        '{1'b1,1'b0,8'hA0, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h34, 4'd2}, // R2 pre-inc
        '{1'b1,1'b0,8'h90, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h35, 4'd3}, // R3 inc seen
        '{1'b1,1'b0,8'hA9, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h34, 4'd3}, // R3 dec seen
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'hFF, 4'd4}, // R4 now AR1
        '{1'b1,1'b0,8'hA0, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'hFF, 4'd2}, // R2 AR1 pre-inc
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd3}, // R3 00FF+1
        '{1'b1,1'b1,8'hA9, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b0,8'h00, 4'd5}, // R5 immediate
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd5}, // R5 no change
        '{1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0, 1'b0,8'h00, 4'd6}, // R6 ptr load
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h35, 4'd4}, // R4 AR0 got inc
        '{1'b0,1'b0,8'hA9, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b0,8'h00, 4'd5}, // R5 idle
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h35, 4'd5}, // R5 no change
        '{1'b1,1'b0,8'h89, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0, 1'b1,8'h35, 4'd6}, // R6 ptr load wins
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h35, 4'd6}, // R6 still AR0
        '{1'b1,1'b0,8'hA0, 1'b0,1'b0,1'b1,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h35, 4'd6}, // R6 load vs inc
        '{1'b1,1'b0,8'h90, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd6}, // R6 load won
        '{1'b1,1'b0,8'hA0, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'hFF, 4'd3}, // R3 0-1 wraps
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd3}, // R3 FFFF+1 wraps
        '{1'b1,1'b0,8'hB0, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd3}, // R3 code 11
        '{1'b1,1'b0,8'h80, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd3}, // R3 code 11 idle
        '{1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b0,8'h00, 4'd6}, // R6 page load 0
        '{1'b1,1'b0,8'h7F, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h7F, 4'd1}, // R1 page 0 top
        '{1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 1'b1,8'h00, 4'd1}  // R1 offset 0
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {vld,addr} actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic imm, input logic [7:0] insn);
        insn_en = en; insn_imm = imm; insn_word = {8'h00, insn};
    endtask

    task automatic clear_loads();
        page_ld = 1'b0; aux_ld = 1'b0; ptr_ld = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R7: valid stays low during reset even with a direct access presented
        @(negedge clk); drive(1'b1, 1'b0, 8'h05); #1;
        check("R7", {dmem_addr_vld, 8'h00}, 9'h000);
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; drive(1'b0, 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].en, VEC[i].imm, VEC[i].insn);
            page_ld = VEC[i].pl; page_val = VEC[i].pv;
            aux_ld = VEC[i].al; aux_sel = VEC[i].as; aux_val = VEC[i].av;
            ptr_ld = VEC[i].xl; ptr_val = VEC[i].xv;
            #1;
            check($sformatf("R%0d vec %0d", VEC[i].req, i),
                  {dmem_addr_vld, (dmem_addr_vld ? dmem_addr : 8'h00)},
                  {VEC[i].evld, VEC[i].eaddr});
        end

        // Directed: load all registers, then reset mid-run (R7)
        @(negedge clk); drive(1'b0, 1'b0, 8'h00);
        page_ld = 1'b1; page_val = 1'b1;
        aux_ld = 1'b1; aux_sel = 1'b1; aux_val = 16'h0055;
        ptr_ld = 1'b1; ptr_val = 1'b1;
        @(negedge clk); clear_loads(); drive(1'b1, 1'b0, 8'h80); #1;
        check("R6 directed AR1", {dmem_addr_vld, dmem_addr}, 9'h155);
        @(negedge clk); rst = 1'b1; drive(1'b1, 1'b0, 8'h22); #1;
        check("R7 vld in reset", {dmem_addr_vld, 8'h00}, 9'h000);
        @(negedge clk); rst = 1'b0; #1;
        check("R7 page cleared", {dmem_addr_vld, dmem_addr}, 9'h122);
        @(negedge clk); drive(1'b1, 1'b0, 8'h89); #1;
        check("R7 ptr and AR0 cleared", {dmem_addr_vld, dmem_addr}, 9'h100);
        @(negedge clk); drive(1'b1, 1'b0, 8'h80); #1;
        check("R7 AR1 cleared", {dmem_addr_vld, dmem_addr}, 9'h100);
        // R4: pointer change plus decrement hits the old register (AR1 -> FFFF, then AR0)
        @(negedge clk); drive(1'b1, 1'b0, 8'h98); #1;
        check("R4 old reg addr", {dmem_addr_vld, dmem_addr}, 9'h100);
        @(negedge clk); drive(1'b1, 1'b0, 8'h80); #1;
        check("R4 AR0 untouched", {dmem_addr_vld, dmem_addr}, 9'h100);
        @(negedge clk); drive(1'b1, 1'b0, 8'h89); #1;
        @(negedge clk); drive(1'b1, 1'b0, 8'h80); #1;
        check("R4 AR1 decremented", {dmem_addr_vld, dmem_addr}, 9'h1FF);

        @(negedge clk); drive(1'b0, 1'b0, 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule